// File: doc/BRIEF.md
# Comparator-Based Event Timer

This block is one timer instance that watches a free-running 64-bit system count supplied from outside. Software programs a 64-bit absolute deadline. It can write that deadline directly, or it can write a signed 32-bit offset that the block adds to the count at the moment of the write. While the timer is switched on and the count has reached the deadline, the block holds a level interrupt high, unless that interrupt is masked.

A single register port serves both writes and reads. Writes take effect on the rising clock edge. Reads are combinational from the selected register.

The relative view of the deadline is the low 32 bits of deadline minus count. Software uses it to see how many ticks remain. Once the deadline has passed, this value keeps falling below zero.

The count itself never raises an interrupt. Only a programmed and enabled timer does.

Top module: `evt_timer`

## Requirements
- R1: After reset the control register reads 0, the absolute deadline reads 0 and the interrupt is low.
- R2: A write with select 1 loads all 64 bits of write data into the absolute deadline. A read with select 1 returns the deadline.
- R3: A write with select 2 sets the deadline to the system count at that clock edge plus the sign-extended low 32 bits of write data, modulo 2^64.
- R4: A read with select 2 returns the low 32 bits of (deadline minus count), sign-extended to 64 bits. The value turns negative once the count passes the deadline.
- R5: The timer condition is an unsigned 64-bit comparison, count greater than or equal to deadline. It is met when the two are equal.
- R6: The interrupt is high exactly when enable is 1, mask is 0 and the condition holds. It stays high for as long as these three hold.
- R7: The interrupt falls when a write moves the deadline past the count, or when enable is cleared.
- R8: The control register is select 0. Bit 0 is enable and bit 1 is mask. Bit 2 is read-only status, equal to enable AND condition, and writes to bit 2 are ignored.
- R9: A write with select 3 changes no state, and a read with select 3 returns 0. With the write strobe low, no register changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sys_count | input | 64 | Free-running system count |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 control, 1 absolute, 2 relative, 3 none) |
| wr_data | input | 64 | Write data |
| rd_sel | input | 2 | Read register select, same encoding |
| rd_data | output | 64 | Read data |
| irq | output | 1 | Level interrupt |

## Verification
Two situations are hardest to reach from the ports.

The first is where signed-offset arithmetic and unsigned comparison disagree. The bench drives the count near 2^64 and writes a small positive offset, so the deadline wraps to a small value and the interrupt must fire at once. It also loads a deadline with the top bit set against a small count, where the interrupt must stay low.

The second is the negative relative reading. The bench reaches it by letting the count run past an armed deadline without rewriting it.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL = 2'd0,
        SEL_ABS  = 2'd1,
        SEL_REL  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic mask;
        logic en;
    } ctrl_t;

endpackage

// File: rtl/evt_regs.sv
module evt_regs
    import evt_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned REL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] sys_count,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    output logic [CNT_W-1:0] cval,
    output ctrl_t            ctrl
);
    localparam int unsigned EXT_W = CNT_W - REL_W;

    typedef struct packed {
        logic [CNT_W-1:0] cval;
        ctrl_t            ctrl;
    } state_t;

    state_t st_d, st_q;
    logic [CNT_W-1:0] offs_ext;

    always_comb begin
        offs_ext = {{EXT_W{wr_data[REL_W-1]}}, wr_data[REL_W-1:0]};
        st_d = st_q;
        if (wr_en) begin
            case (reg_sel_e'(wr_sel))
                SEL_CTRL: begin
                    st_d.ctrl.en   = wr_data[0];
                    st_d.ctrl.mask = wr_data[1];
                end
                SEL_ABS:  st_d.cval = wr_data;
                SEL_REL:  st_d.cval = sys_count + offs_ext;
                default:  st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cval = st_q.cval;
    assign ctrl = st_q.ctrl;

    AST_ABS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1) |=> (cval == $past(wr_data))); // R2
    AST_REL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> ((cval - $past(sys_count)) ==
            {{EXT_W{$past(wr_data[REL_W-1])}}, $past(wr_data[REL_W-1:0])})); // R3
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel == 2'd3) |=> ($stable(cval) && $stable(ctrl))); // R9
endmodule

// File: rtl/evt_cmp.sv
module evt_cmp #(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned REL_W = 32
) (
    input  logic [CNT_W-1:0] sys_count,
    input  logic [CNT_W-1:0] cval,
    output logic             cond,
    output logic [REL_W-1:0] rel_view
);
    always_comb begin
        cond     = (sys_count >= cval);
        rel_view = cval[REL_W-1:0] - sys_count[REL_W-1:0];
    end
endmodule

// File: rtl/evt_irq.sv
module evt_irq
    import evt_timer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  ctrl_t ctrl,
    input  logic  cond,
    output logic  status,
    output logic  irq
);
    always_comb begin
        status = ctrl.en & cond;
        irq    = status & ~ctrl.mask;
    end

    AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ctrl.en && !ctrl.mask)); // R6
    AST_STATUS_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        status |-> ctrl.en); // R8
endmodule

// File: rtl/evt_timer.sv
module evt_timer
    import evt_timer_pkg::*;
#(
    parameter int unsigned CNT_W = 64,
    parameter int unsigned REL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] sys_count,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    output logic [CNT_W-1:0] rd_data,
    output logic             irq
);
    localparam int unsigned EXT_W = CNT_W - REL_W;

    logic [CNT_W-1:0] cval;
    ctrl_t            ctrl;
    logic             cond;
    logic             status;
    logic [REL_W-1:0] rel_view;

    evt_regs #(.CNT_W(CNT_W), .REL_W(REL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sys_count(sys_count),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cval(cval), .ctrl(ctrl)
    );

    evt_cmp #(.CNT_W(CNT_W), .REL_W(REL_W)) u_cmp (
        .sys_count(sys_count), .cval(cval), .cond(cond), .rel_view(rel_view)
    );

    evt_irq u_irq (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .cond(cond),
        .status(status), .irq(irq)
    );

    always_comb begin
        case (reg_sel_e'(rd_sel))
            SEL_CTRL: rd_data = {{(CNT_W-3){1'b0}}, status, ctrl.mask, ctrl.en};
            SEL_ABS:  rd_data = cval;
            SEL_REL:  rd_data = {{EXT_W{rel_view[REL_W-1]}}, rel_view};
            default:  rd_data = '0;
        endcase
    end

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq) && !$past(wr_en) && sys_count >= $past(sys_count)) |-> irq); // R6
    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && !wr_data[0]) |=> !irq); // R7
    AST_NO_IRQ_AFTER_RESET: assert property (@(posedge clk)
        $rose(rst_n) |-> !irq); // R1
endmodule

// File: tb/evt_timer_bench.sv
module evt_timer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] sys_count = 64'd100;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [63:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [63:0] rd_data;
    logic        irq;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [2:0]  sel_q[$];
    logic [63:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    evt_timer u_evt_timer (
        .clk(clk), .rst_n(rst_n), .sys_count(sys_count),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            logic [2:0]  s;
            logic [63:0] e;
            logic [63:0] a;
            string       t;
            wait (sel_q.size() > 0);
            s = sel_q[0];
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            rd_sel = s[1:0];
            #1;
            a = s[2] ? {63'd0, irq} : rd_data;
            checks++;
            if (a !== e) begin
                fails++;
                $display("FAIL %s actual=%h expected=%h", t, a, e);
            end
            void'(sel_q.pop_front());
        end
    end

    task automatic push(input logic is_irq, input logic [1:0] s,
                        input logic [63:0] e, input string t);
        sel_q.push_back({is_irq, s});
        exp_q.push_back(e);
        tag_q.push_back(t);
    endtask

    task automatic settle();
        wait (sel_q.size() == 0);
        #2;
    endtask

    task automatic step(input logic w, input logic [1:0] s,
                        input logic [63:0] d, input logic [63:0] c);
        @(negedge clk);
        wr_en = w; wr_sel = s; wr_data = d; sys_count = c;
        @(posedge clk);
        #2;
        wr_en = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        step(1'b0, 2'd0, 64'd0, 64'd100);
        push(1, 0, 64'd0, "R1 irq after reset");
        push(0, 0, 64'd0, "R1 ctrl after reset");
        push(0, 1, 64'd0, "R1 deadline after reset");
        push(0, 2, -64'sd100, "R4 rel view after reset");
        settle();

        step(1'b1, 2'd1, 64'd150, 64'd100);
        push(0, 1, 64'd150, "R2 absolute load");
        push(0, 2, 64'd50, "R4 rel remaining");
        push(1, 0, 64'd0, "R6 disabled no irq");
        settle();

        step(1'b1, 2'd0, 64'd1, 64'd100);
        push(0, 0, 64'd1, "R8 enabled not reached");
        push(1, 0, 64'd0, "R5 count below deadline");
        settle();

        step(1'b0, 2'd0, 64'd0, 64'd150);
        push(1, 0, 64'd1, "R5 equality fires");
        push(0, 0, 64'd5, "R8 status set");
        push(0, 2, 64'd0, "R4 rel zero");
        settle();

        for (int i = 0; i < 5; i++) step(1'b0, 2'd0, 64'd0, 64'd151 + 64'(i));
        push(1, 0, 64'd1, "R6 level held");
        push(0, 2, -64'sd5, "R4 rel negative");
        settle();

        step(1'b1, 2'd0, 64'd3, 64'd160);
        push(1, 0, 64'd0, "R6 masked");
        push(0, 0, 64'd7, "R8 status while masked");
        settle();

        step(1'b1, 2'd0, 64'd4, 64'd160);
        push(0, 0, 64'd0, "R8 status bit not writable");
        push(1, 0, 64'd0, "R7 disabled");
        settle();

        step(1'b1, 2'd0, 64'd1, 64'd165);
        push(1, 0, 64'd1, "R6 re-enabled");
        settle();

        step(1'b1, 2'd2, 64'd1000, 64'd170);
        push(1, 0, 64'd0, "R7 deadline moved ahead");
        push(0, 1, 64'd1170, "R3 relative load");
        push(0, 2, 64'd1000, "R4 rel after write");
        settle();

        step(1'b0, 2'd0, 64'd0, 64'd175);
        push(0, 2, 64'd995, "R4 rel decrements");
        settle();

        step(1'b1, 2'd2, 64'h0000_0000_FFFF_FFF6, 64'd200);
        push(0, 1, 64'd190, "R3 negative offset");
        push(1, 0, 64'd1, "R6 fires after past deadline");
        settle();

        step(1'b1, 2'd2, 64'hFFFF_FFFF_0000_0020, 64'hFFFF_FFFF_FFFF_FFF0);
        push(0, 1, 64'h10, "R3 wrap modulo 2^64");
        push(1, 0, 64'd1, "R5 unsigned after wrap");
        push(0, 2, 64'h20, "R4 rel after wrap");
        settle();

        step(1'b1, 2'd1, 64'h8000_0000_0000_0000, 64'd5);
        push(1, 0, 64'd0, "R5 unsigned large deadline");
        settle();

        step(1'b1, 2'd3, 64'd77, 64'd6);
        push(0, 1, 64'h8000_0000_0000_0000, "R9 select 3 deadline kept");
        push(0, 0, 64'd1, "R9 select 3 ctrl kept");
        push(0, 3, 64'd0, "R9 select 3 reads zero");
        settle();

        step(1'b1, 2'd1, 64'd2, 64'd6);
        push(1, 0, 64'd1, "R6 absolute deadline passed");
        settle();

        step(1'b1, 2'd0, 64'd0, 64'd7);
        push(1, 0, 64'd0, "R7 disable drops irq");
        push(0, 0, 64'd0, "R8 status clears on disable");
        settle();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule